// File: doc/BRIEF.md
# Frame-Indexed Address Translation Table

This block turns a logical address into a physical address. The logical address has three parts: a process ID, a page number and a page offset. All processes share one table, and it has one entry for each physical frame. The position of an entry is the number of the frame it describes. Each entry holds a valid flag, the owning process ID, the page number, a protection field, a dirty flag and a referenced flag.

A lookup walks the table one entry per clock cycle. It starts at frame 0 and compares the request's process ID and page number with each valid entry. The walk stops at the first entry that matches. The index of that entry becomes the upper part of the physical address, and the request's page offset becomes the lower part. If the walk reaches the last frame without a match, the block reports a page fault. A write port loads or clears one entry at a time. A read port shows any entry directly, so that software can inspect the referenced and dirty flags.

Top module: `ipt_engine`

## Requirements
- R1: After reset, `idle` is 1, `done` and `fault` are 0, and every entry reads back with `rd_valid` = 0.
- R2: A request is taken only in a cycle where `req_valid` and `idle` are both 1. While a lookup is running, `req_valid` has no effect: exactly one `done` pulse follows each accepted request.
- R3: An entry matches only when both its process ID and its page number equal those of the request. An entry with the same page number but a different process ID does not match.
- R4: On a hit, `fault` is 0 and `paddr` is {frame index, request offset}. The frame index fills the upper FRAME_W bits and the offset fills the low OFF_W bits.
- R5: The walk starts at frame 0 and stops at the first match. A hit at frame k raises `done` k+1 cycles after the accepting clock edge, and `idle` is 1 in the same cycle.
- R6: If no valid entry matches, `done` and `fault` are both 1 FRAMES cycles after the accepting edge. `fault` is never 1 without `done`.
- R7: An entry with its valid flag clear is never reported as a match, even when its process ID and page number are equal to the request's.
- R8: A hit sets the matching entry's referenced flag. It also sets the dirty flag when `req_write` was 1 at acceptance. A read hit leaves the dirty flag unchanged.
- R9: A write with `wr_en` = 1 while idle loads every field of entry `wr_frame` in one cycle. The new contents show on the read port after that clock edge. Writing `wr_valid` = 0 clears the entry.
- R10: A write presented while a lookup is running is ignored, and the entry keeps its contents.
- R11: `done` is high for exactly one cycle per lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_pid | input | PID_W | Process ID of request |
| req_page | input | PAGE_W | Page number of request |
| req_off | input | OFF_W | Page offset of request |
| req_write | input | 1 | Request is a store (sets dirty on hit) |
| idle | output | 1 | Engine ready for a request or a write |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Page fault, valid with done |
| paddr | output | FRAME_W+OFF_W | Physical address, valid with done and no fault |
| wr_en | input | 1 | Load entry |
| wr_frame | input | FRAME_W | Entry to load |
| wr_valid | input | 1 | Valid flag to store |
| wr_pid | input | PID_W | Process ID to store |
| wr_page | input | PAGE_W | Page number to store |
| wr_prot | input | PROT_W | Protection bits to store |
| wr_dirty | input | 1 | Dirty flag to store |
| wr_ref | input | 1 | Referenced flag to store |
| rd_frame | input | FRAME_W | Entry to inspect |
| rd_valid | output | 1 | Valid flag of inspected entry |
| rd_pid | output | PID_W | Process ID of inspected entry |
| rd_page | output | PAGE_W | Page number of inspected entry |
| rd_prot | output | PROT_W | Protection of inspected entry |
| rd_dirty | output | 1 | Dirty flag of inspected entry |
| rd_ref | output | 1 | Referenced flag of inspected entry |

## Verification
The checker assumes that `wr_frame` and `rd_frame` are always below FRAMES. It latches the request offset on the accepting edge, so it does not require the request inputs to stay stable after that edge. The stimulus only uses frame numbers inside the table. It changes inputs at the falling edge. It presents writes and new requests during a scan on purpose, to show that they are ignored.

// File: rtl/ipt_engine.sv
module ipt_engine #(
  parameter int FRAMES = 16,
  parameter int PID_W  = 4,
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 10,
  parameter int PROT_W = 2,
  localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int PA_W    = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [PID_W-1:0]   req_pid,
  input  logic [PAGE_W-1:0]  req_page,
  input  logic [OFF_W-1:0]   req_off,
  input  logic               req_write,
  output logic               idle,
  output logic               done,
  output logic               fault,
  output logic [PA_W-1:0]    paddr,
  input  logic               wr_en,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_valid,
  input  logic [PID_W-1:0]   wr_pid,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [PROT_W-1:0]  wr_prot,
  input  logic               wr_dirty,
  input  logic               wr_ref,
  input  logic [FRAME_W-1:0] rd_frame,
  output logic               rd_valid,
  output logic [PID_W-1:0]   rd_pid,
  output logic [PAGE_W-1:0]  rd_page,
  output logic [PROT_W-1:0]  rd_prot,
  output logic               rd_dirty,
  output logic               rd_ref
);

  logic              t_valid [FRAMES];
  logic [PID_W-1:0]  t_pid   [FRAMES];
  logic [PAGE_W-1:0] t_page  [FRAMES];
  logic [PROT_W-1:0] t_prot  [FRAMES];
  logic              t_dirty [FRAMES];
  logic              t_ref   [FRAMES];

  logic               busy_q, done_q, fault_q, s_wr;
  logic [FRAME_W-1:0] idx_q;
  logic [PID_W-1:0]   s_pid;
  logic [PAGE_W-1:0]  s_page;
  logic [OFF_W-1:0]   s_off;
  logic [PA_W-1:0]    paddr_q;

  wire hit  = t_valid[idx_q] && (t_pid[idx_q] == s_pid) && (t_page[idx_q] == s_page);
  wire last = (idx_q == FRAME_W'(FRAMES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
      idx_q   <= '0;
      s_pid   <= '0;
      s_page  <= '0;
      s_off   <= '0;
      s_wr    <= 1'b0;
      for (int i = 0; i < FRAMES; i++) begin
        t_valid[i] <= 1'b0;
        t_pid[i]   <= '0;
        t_page[i]  <= '0;
        t_prot[i]  <= '0;
        t_dirty[i] <= 1'b0;
        t_ref[i]   <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (wr_en) begin
          t_valid[wr_frame] <= wr_valid;
          t_pid[wr_frame]   <= wr_pid;
          t_page[wr_frame]  <= wr_page;
          t_prot[wr_frame]  <= wr_prot;
          t_dirty[wr_frame] <= wr_dirty;
          t_ref[wr_frame]   <= wr_ref;
        end
        if (req_valid) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          s_pid  <= req_pid;
          s_page <= req_page;
          s_off  <= req_off;
          s_wr   <= req_write;
        end
      end else if (hit) begin
        busy_q       <= 1'b0;
        done_q       <= 1'b1;
        fault_q      <= 1'b0;
        paddr_q      <= {idx_q, s_off};
        t_ref[idx_q] <= 1'b1;
        if (s_wr) t_dirty[idx_q] <= 1'b1;
      end else if (last) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        fault_q <= 1'b1;
        paddr_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign idle  = !busy_q;
  assign done  = done_q;
  assign fault = done_q && fault_q;
  assign paddr = paddr_q;

  assign rd_valid = t_valid[rd_frame];
  assign rd_pid   = t_pid[rd_frame];
  assign rd_page  = t_page[rd_frame];
  assign rd_prot  = t_prot[rd_frame];
  assign rd_dirty = t_dirty[rd_frame];
  assign rd_ref   = t_ref[rd_frame];

endmodule

// File: rtl/ipt_engine_chk.sv
module ipt_engine_chk #(
  parameter int FRAMES = 16,
  parameter int OFF_W  = 10,
  parameter int PA_W   = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_off,
  input logic             idle,
  input logic             done,
  input logic             fault,
  input logic [PA_W-1:0]  paddr
);

  logic [OFF_W-1:0] off_q;
  int unsigned      scan_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q    <= '0;
      scan_cnt <= 0;
    end else begin
      if (idle && req_valid) off_q <= req_off;
      scan_cnt <= idle ? 0 : scan_cnt + 1;
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req_valid) |=> !idle); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done); // R6
  AST_DONE_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle); // R5
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (paddr[OFF_W-1:0] == off_q)); // R4
  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (scan_cnt < FRAMES)); // R6

endmodule

bind ipt_engine ipt_engine_chk #(.FRAMES(FRAMES), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_off(req_off),
  .idle(idle), .done(done), .fault(fault), .paddr(paddr)
);

// File: tb/sim_ipt_engine.sv
module sim_ipt_engine;
  localparam int FRAMES = 16, PID_W = 4, PAGE_W = 8, OFF_W = 10, PROT_W = 2;
  localparam int FRAME_W = 4, PA_W = FRAME_W + OFF_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [PID_W-1:0] req_pid = '0;
  logic [PAGE_W-1:0] req_page = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic idle, done, fault;
  logic [PA_W-1:0] paddr;
  logic wr_en = 0, wr_valid = 0, wr_dirty = 0, wr_ref = 0;
  logic [FRAME_W-1:0] wr_frame = '0, rd_frame = '0;
  logic [PID_W-1:0] wr_pid = '0, rd_pid;
  logic [PAGE_W-1:0] wr_page = '0, rd_page;
  logic [PROT_W-1:0] wr_prot = '0, rd_prot;
  logic rd_valid, rd_dirty, rd_ref;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ipt_engine #(.FRAMES(FRAMES), .PID_W(PID_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .PROT_W(PROT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pid(req_pid), .req_page(req_page),
    .req_off(req_off), .req_write(req_write), .idle(idle), .done(done), .fault(fault), .paddr(paddr),
    .wr_en(wr_en), .wr_frame(wr_frame), .wr_valid(wr_valid), .wr_pid(wr_pid), .wr_page(wr_page),
    .wr_prot(wr_prot), .wr_dirty(wr_dirty), .wr_ref(wr_ref), .rd_frame(rd_frame),
    .rd_valid(rd_valid), .rd_pid(rd_pid), .rd_page(rd_page), .rd_prot(rd_prot),
    .rd_dirty(rd_dirty), .rd_ref(rd_ref));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_entry(input int fr, input bit v, input int pid, input int page,
                             input int prot, input bit d, input bit r);
    @(negedge clk);
    wr_en = 1; wr_frame = fr[FRAME_W-1:0]; wr_valid = v; wr_pid = pid[PID_W-1:0];
    wr_page = page[PAGE_W-1:0]; wr_prot = prot[PROT_W-1:0]; wr_dirty = d; wr_ref = r;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(input int pid, input int page, input int off, input bit wr,
                        input bit exp_fault, input int exp_frame, input int exp_lat, input string tag);
    int cyc;
    @(negedge clk);
    req_valid = 1; req_pid = pid[PID_W-1:0]; req_page = page[PAGE_W-1:0];
    req_off = off[OFF_W-1:0]; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == exp_lat, {tag, " latency"}, cyc, exp_lat);
    check(fault == exp_fault, {tag, " fault"}, fault, exp_fault);
    check(idle == 1, {tag, " idle at done R5"}, idle, 1);
    if (!exp_fault)
      check(paddr == {exp_frame[FRAME_W-1:0], off[OFF_W-1:0]}, {tag, " paddr R4"}, paddr,
            {exp_frame[FRAME_W-1:0], off[OFF_W-1:0]});
    @(negedge clk);
    check(done == 0, {tag, " done single cycle R11"}, done, 0);
  endtask

  task automatic read_entry(input int fr, output logic [31:0] packed_e);
    rd_frame = fr[FRAME_W-1:0];
    #1;
    packed_e = {13'd0, rd_valid, rd_pid, rd_page, rd_prot, rd_dirty, rd_ref};
  endtask

  task automatic t_reset();
    logic [31:0] e;
    bit all_clear = 1;
    check(idle == 1 && done == 0 && fault == 0, "R1 idle/done/fault after reset",
          {idle, done, fault}, 3'b100);
    for (int i = 0; i < FRAMES; i++) begin
      read_entry(i, e);
      if (rd_valid) all_clear = 0;
    end
    check(all_clear, "R1 all entries invalid", all_clear, 1);
  endtask

  task automatic t_write_read();
    logic [31:0] e;
    write_entry(3, 1, 2, 'h11, 2, 0, 0);
    read_entry(3, e);
    check(e == {13'd0, 1'b1, 4'd2, 8'h11, 2'd2, 1'b0, 1'b0}, "R9 load all fields", e,
          {13'd0, 1'b1, 4'd2, 8'h11, 2'd2, 1'b0, 1'b0});
    write_entry(12, 1, 1, 'h40, 1, 1, 1);
    read_entry(12, e);
    check(e == {13'd0, 1'b1, 4'd1, 8'h40, 2'd1, 1'b1, 1'b1}, "R9 load second entry", e,
          {13'd0, 1'b1, 4'd1, 8'h40, 2'd1, 1'b1, 1'b1});
  endtask

  task automatic t_hit();
    lookup(2, 'h11, 'h155, 0, 0, 3, 4, "R5 hit frame3");
    lookup(1, 'h40, 'h3ff, 0, 0, 12, 13, "R4 hit frame12");
  endtask

  task automatic t_pid_ambig();
    write_entry(1, 1, 5, 'h11, 0, 0, 0);
    lookup(7, 'h11, 'h001, 0, 1, 0, FRAMES, "R3 other pid miss R6");
    lookup(5, 'h11, 'h2aa, 0, 0, 1, 2, "R3 pid5 frame1");
  endtask

  task automatic t_first_match();
    write_entry(9, 1, 2, 'h11, 0, 0, 0);
    lookup(2, 'h11, 'h0f0, 0, 0, 3, 4, "R5 first match frame3");
  endtask

  task automatic t_invalid();
    logic [31:0] e;
    write_entry(3, 0, 2, 'h11, 0, 0, 0);
    read_entry(3, e);
    check(rd_valid == 0, "R9 clear entry", rd_valid, 0);
    lookup(2, 'h11, 'h033, 0, 0, 9, 10, "R7 skip invalid frame3");
    write_entry(9, 0, 2, 'h11, 0, 0, 0);
    lookup(2, 'h11, 'h033, 0, 1, 0, FRAMES, "R7 all invalid miss");
  endtask

  task automatic t_ref_dirty();
    logic [31:0] e;
    write_entry(1, 1, 5, 'h11, 0, 0, 0);
    lookup(5, 'h11, 'h010, 0, 0, 1, 2, "R8 read hit");
    read_entry(1, e);
    check(rd_ref == 1, "R8 ref set on read hit", rd_ref, 1);
    check(rd_dirty == 0, "R8 dirty kept on read hit", rd_dirty, 0);
    lookup(5, 'h11, 'h020, 1, 0, 1, 2, "R8 write hit");
    read_entry(1, e);
    check(rd_dirty == 1, "R8 dirty set on write hit", rd_dirty, 1);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] e;
    int cyc, dones;
    @(negedge clk);
    req_valid = 1; req_pid = 4'd7; req_page = 8'h11; req_off = '0; req_write = 0;
    @(negedge clk);
    req_valid = 0;
    cyc = 0; dones = 0;
    repeat (3) begin @(negedge clk); cyc++; end
    wr_en = 1; wr_frame = 4'd0; wr_valid = 1; wr_pid = 4'd7; wr_page = 8'h11;
    wr_prot = 0; wr_dirty = 0; wr_ref = 0;
    req_valid = 1; req_pid = 4'd5; req_page = 8'h11;
    @(negedge clk); cyc++;
    wr_en = 0; req_valid = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    check(cyc == FRAMES && fault == 1, "R10 scan unaffected by write (fault)", cyc, FRAMES);
    repeat (FRAMES + 2) begin @(negedge clk); if (done) dones++; end
    check(dones == 0, "R2 request during scan ignored", dones, 0);
    read_entry(0, e);
    check(rd_valid == 0, "R10 write during scan ignored", rd_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_hit();
    t_pid_ambig();
    t_first_match();
    t_invalid();
    t_ref_dirty();
    t_busy_ignore();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule